// File: doc/BRIEF.md
# Test Instruction Decoder and Serial Path Selector

This block is the test logic that sits behind a TAP state machine. It keeps an instruction register that is shifted serially from TDI, turns the active instruction into pin-control modes for a boundary register, and decides which data register lies between TDI and TDO while data is shifted. It contains a one-bit bypass register and a 32-bit identification register. The identification register can capture either a fixed identity word or a user-supplied code.

The TAP state machine is not part of the block. It supplies one strobe per controller state that the block reacts to: reset, capture, shift and update for the instruction register, and capture and shift for the data registers. The boundary register is also outside the block. Its serial output comes back on an input, and the block tells it whether it sits in the serial path, whether it drives the device pins, and whether it feeds the core inputs.

Both the serial path and the pin modes come from one decoded instruction. This lets the clamp instruction route the serial path through bypass while the pins stay held by the boundary register.

Top module: `tip_core`

## Requirements
- R1: While `trst_n` is low, the active instruction is IDCODE (opcode 0010) at once. A cycle with `st_reset` high makes it IDCODE at the next rising edge. In both cases all mode outputs are low, and `tdo_en` and `tdo` are low.
- R2: A capture-IR cycle loads the instruction shift register with 01 in its two least significant bits and zeros above. Shifting it out then shows 1, 0, 0, 0 on TDO.
- R3: The instruction shift register takes TDI at its most significant bit and shifts toward bit 0. The active instruction, and so every mode output, stays unchanged until an update-IR cycle.
- R4: Opcode 1111 (BYPASS) and every unused opcode select the bypass register. It captures 0 on capture-DR, and each bit entered on TDI appears on TDO one shift later. All mode outputs are low.
- R5: Opcode 0000 (EXTEST) sets `sel_bsr` and `pin_from_bsr`. Opcode 0001 (SAMPLE/PRELOAD) sets only `sel_bsr`. While `sel_bsr` is high, TDO follows `bsr_so` during shift-DR.
- R6: Opcode 0010 (IDCODE) selects the identification register. On capture-DR it loads version in bits 31:28, part number in bits 27:12, maker code in bits 11:1 and a 1 in bit 0. The word shifts out bit 0 first.
- R7: Opcode 0011 (USERCODE) selects the identification register. It loads `user_code` as it stands at the rising edge that ends the capture-DR cycle; later changes to `user_code` have no effect on the bits shifted out.
- R8: Opcode 0100 (CLAMP) selects the bypass register for the serial path and sets `pin_from_bsr`, with `sel_bsr` low.
- R9: Opcode 0101 (HIGHZ) sets `pins_hiz`, keeps `pin_from_bsr` and `sel_bsr` low, and selects bypass.
- R10: Opcode 0110 (INTEST) sets `sel_bsr`, `pin_from_bsr` and `core_from_bsr`.
- R11: TDO and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only for a cycle in shift-IR or shift-DR, and TDO is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset, released on a rising `tck` edge |
| st_reset | input | 1 | TAP is in test-logic-reset |
| st_cap_ir | input | 1 | TAP is in capture-IR |
| st_shift_ir | input | 1 | TAP is in shift-IR |
| st_upd_ir | input | 1 | TAP is in update-IR |
| st_cap_dr | input | 1 | TAP is in capture-DR |
| st_shift_dr | input | 1 | TAP is in shift-DR |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| user_code | input | 32 | User-programmable identification code |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for TDO |
| sel_bsr | output | 1 | Boundary register is in the serial path |
| pin_from_bsr | output | 1 | Device pins are driven from the boundary register |
| core_from_bsr | output | 1 | Core inputs are taken from the boundary register |
| pins_hiz | output | 1 | All device outputs are forced to high impedance |

## Verification
Mode outputs change at the rising edge that ends an update-IR or reset cycle. Capture and shift results reach TDO at the falling edge of the following cycle, so a bit captured in one cycle is seen in the first shift cycle. The bench drives strobes 2 ns after a rising edge and compares every output with its reference model 6 ns after that edge, after the falling edge of the same cycle. One extra check samples TDO just before and just after a falling edge, to show the change happens there. The asynchronous reset is checked 1 ns after `trst_n` falls, with no clock edge in between.

// File: rtl/tip_pkg.sv
package tip_pkg;
  // opcode values, cast to the instruction width where used
  localparam int OPC_EXTEST   = 0;
  localparam int OPC_SAMPLE   = 1;
  localparam int OPC_IDCODE   = 2;
  localparam int OPC_USERCODE = 3;
  localparam int OPC_CLAMP    = 4;
  localparam int OPC_HIGHZ    = 5;
  localparam int OPC_INTEST   = 6;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } tip_path_t;

  typedef struct packed {
    tip_path_t path;
    logic      id_user;
    logic      pin_from_bsr;
    logic      core_from_bsr;
    logic      pins_hiz;
  } tip_mode_t;
endpackage

// File: rtl/tip_ir.sv
module tip_ir #(
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] RESET_OP = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_reset,
  input  logic            cap,
  input  logic            shift,
  input  logic            upd,
  input  logic            tdi,
  output logic            sr_lsb,
  output logic [IR_W-1:0] ir_q
);
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(2'b01);

  logic [IR_W-1:0] sr_q, sr_nxt, ir_nxt;
  logic            sr_en, ir_en;

  always_comb begin
    sr_en  = cap | shift;
    sr_nxt = sr_q;
    if (cap)        sr_nxt = CAP_PAT;
    else if (shift) sr_nxt = {tdi, sr_q[IR_W-1:1]};
  end

  always_comb begin
    ir_en  = st_reset | upd;
    ir_nxt = ir_q;
    if (st_reset) ir_nxt = RESET_OP;
    else if (upd) ir_nxt = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= RESET_OP;
    else if (ir_en) ir_q <= ir_nxt;
  end

  assign sr_lsb = sr_q[0];
endmodule

// File: rtl/tip_decode.sv
module tip_decode
  import tip_pkg::*;
#(
  parameter int IR_W   = 4,
  parameter bit HAS_ID = 1'b1
) (
  input  logic [IR_W-1:0] ir,
  output tip_mode_t       mode
);
  localparam tip_path_t ID_PATH = HAS_ID ? PATH_ID : PATH_BYP;

  always_comb begin
    mode = '{path: PATH_BYP, id_user: 1'b0, pin_from_bsr: 1'b0,
             core_from_bsr: 1'b0, pins_hiz: 1'b0};
    case (ir)
      IR_W'(OPC_EXTEST): begin
        mode.path         = PATH_BSR;
        mode.pin_from_bsr = 1'b1;
      end
      IR_W'(OPC_SAMPLE):   mode.path = PATH_BSR;
      IR_W'(OPC_IDCODE):   mode.path = ID_PATH;
      IR_W'(OPC_USERCODE): begin
        mode.path    = ID_PATH;
        mode.id_user = HAS_ID;
      end
      IR_W'(OPC_CLAMP):    mode.pin_from_bsr = 1'b1;
      IR_W'(OPC_HIGHZ):    mode.pins_hiz = 1'b1;
      IR_W'(OPC_INTEST): begin
        mode.path          = PATH_BSR;
        mode.pin_from_bsr  = 1'b1;
        mode.core_from_bsr = 1'b1;
      end
      default: ; // all ones and unused codes: bypass
    endcase
  end
endmodule

// File: rtl/tip_dr.sv
module tip_dr
  import tip_pkg::*;
#(
  parameter int               ID_W    = 32,
  parameter bit               HAS_ID  = 1'b1,
  parameter logic [ID_W-1:0]  ID_WORD = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic            shift,
  input  logic            tdi,
  input  tip_path_t       path,
  input  logic            id_user,
  input  logic [ID_W-1:0] user_code,
  output logic            byp_lsb,
  output logic            id_lsb
);
  logic byp_q, byp_nxt, byp_en, byp_sel;

  assign byp_sel = (path == PATH_BYP);

  always_comb begin
    byp_en  = byp_sel & (cap | shift);
    byp_nxt = cap ? 1'b0 : tdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_nxt;
  end

  assign byp_lsb = byp_q;

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_q, id_nxt;
      logic            id_en, id_sel;

      assign id_sel = (path == PATH_ID);

      always_comb begin
        id_en  = id_sel & (cap | shift);
        id_nxt = id_q;
        if (cap)        id_nxt = id_user ? user_code : ID_WORD;
        else if (shift) id_nxt = {tdi, id_q[ID_W-1:1]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     id_q <= ID_WORD;
        else if (id_en) id_q <= id_nxt;
      end

      assign id_lsb = id_q[0];
    end else begin : g_no_id
      assign id_lsb = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tip_core.sv
module tip_core
  import tip_pkg::*;
#(
  parameter int          IR_W    = 4,
  parameter bit          HAS_ID  = 1'b1,
  parameter logic [3:0]  ID_VER  = 4'h3,
  parameter logic [15:0] ID_PART = 16'hA51C,
  parameter logic [10:0] ID_MFR  = 11'h2B5
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        st_reset,
  input  logic        st_cap_ir,
  input  logic        st_shift_ir,
  input  logic        st_upd_ir,
  input  logic        st_cap_dr,
  input  logic        st_shift_dr,
  input  logic        tdi,
  input  logic        bsr_so,
  input  logic [31:0] user_code,
  output logic        tdo,
  output logic        tdo_en,
  output logic        sel_bsr,
  output logic        pin_from_bsr,
  output logic        core_from_bsr,
  output logic        pins_hiz
);
  localparam int              ID_W     = 32;
  localparam logic [ID_W-1:0] ID_WORD  = {ID_VER, ID_PART, ID_MFR, 1'b1};
  localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? IR_W'(OPC_IDCODE) : '1;

  // reset: asserted at once, released on a rising tck edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, byp_lsb, id_lsb;
  tip_mode_t       mode;

  tip_ir #(.IR_W(IR_W), .RESET_OP(RESET_OP)) u_ir (
    .clk      (tck),
    .rst_n    (rst_n),
    .st_reset (st_reset),
    .cap      (st_cap_ir),
    .shift    (st_shift_ir),
    .upd      (st_upd_ir),
    .tdi      (tdi),
    .sr_lsb   (ir_lsb),
    .ir_q     (ir_q)
  );

  tip_decode #(.IR_W(IR_W), .HAS_ID(HAS_ID)) u_dec (
    .ir   (ir_q),
    .mode (mode)
  );

  tip_dr #(.ID_W(ID_W), .HAS_ID(HAS_ID), .ID_WORD(ID_WORD)) u_dr (
    .clk       (tck),
    .rst_n     (rst_n),
    .cap       (st_cap_dr),
    .shift     (st_shift_dr),
    .tdi       (tdi),
    .path      (mode.path),
    .id_user   (mode.id_user),
    .user_code (user_code),
    .byp_lsb   (byp_lsb),
    .id_lsb    (id_lsb)
  );

  // serial output selection
  logic dr_bit, tdo_d, en_d;

  always_comb begin
    case (mode.path)
      PATH_ID:  dr_bit = id_lsb;
      PATH_BSR: dr_bit = bsr_so;
      default:  dr_bit = byp_lsb;
    endcase
    en_d = st_shift_ir | st_shift_dr;
    if (st_shift_ir)      tdo_d = ir_lsb;
    else if (st_shift_dr) tdo_d = dr_bit;
    else                  tdo_d = 1'b0;
  end

  // output stage on the falling edge
  logic tdo_q, tdo_en_q;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= en_d;
    end
  end

  assign tdo           = tdo_q;
  assign tdo_en        = tdo_en_q;
  assign sel_bsr       = (mode.path == PATH_BSR);
  assign pin_from_bsr  = mode.pin_from_bsr;
  assign core_from_bsr = mode.core_from_bsr;
  assign pins_hiz      = mode.pins_hiz;
endmodule

// File: rtl/tip_core_chk.sv
module tip_core_chk
  import tip_pkg::*;
#(
  parameter int IR_W = 4
) (
  input logic            tck,
  input logic            rst_n,
  input logic            st_reset,
  input logic            st_upd_ir,
  input logic            st_shift_ir,
  input logic            st_shift_dr,
  input logic [IR_W-1:0] ir_q,
  input logic            tdo,
  input logic            tdo_en,
  input logic            sel_bsr,
  input logic            pin_from_bsr,
  input logic            pins_hiz
);
  // R1
  tlr_to_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    st_reset |=> (ir_q == IR_W'(OPC_IDCODE)));

  // R3
  ir_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!st_upd_ir && !st_reset) |=> $stable(ir_q));

  // R8
  clamp_path_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q == IR_W'(OPC_CLAMP)) |-> (pin_from_bsr && !sel_bsr));

  // R9
  highz_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    pins_hiz |-> (!pin_from_bsr && !sel_bsr));

  // R11
  tdo_en_state_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (st_shift_ir || st_shift_dr));

  // R11
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_en |-> !tdo);
endmodule

bind tip_core tip_core_chk #(.IR_W(IR_W)) u_chk (
  .tck          (tck),
  .rst_n        (rst_n),
  .st_reset     (st_reset),
  .st_upd_ir    (st_upd_ir),
  .st_shift_ir  (st_shift_ir),
  .st_shift_dr  (st_shift_dr),
  .ir_q         (ir_q),
  .tdo          (tdo),
  .tdo_en       (tdo_en),
  .sel_bsr      (sel_bsr),
  .pin_from_bsr (pin_from_bsr),
  .pins_hiz     (pins_hiz)
);

// File: tb/tip_core_bench.sv
`timescale 1ns/1ps
module tip_core_bench;
  localparam int          IR_W = 4;
  localparam logic [31:0] EXP_ID = {4'h3, 16'hA51C, 11'h2B5, 1'b1};

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic trst_n, st_reset, st_cap_ir, st_shift_ir, st_upd_ir, st_cap_dr, st_shift_dr;
  logic tdi, bsr_so;
  logic [31:0] user_code;
  logic tdo, tdo_en, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz;

  tip_core u_tip_core (
    .tck(tck), .trst_n(trst_n), .st_reset(st_reset), .st_cap_ir(st_cap_ir),
    .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr),
    .st_shift_dr(st_shift_dr), .tdi(tdi), .bsr_so(bsr_so), .user_code(user_code),
    .tdo(tdo), .tdo_en(tdo_en), .sel_bsr(sel_bsr), .pin_from_bsr(pin_from_bsr),
    .core_from_bsr(core_from_bsr), .pins_hiz(pins_hiz)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0, cmp_on = 1'b0;
  logic last_tdo, last_en;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_ir, m_irsr, m_cnt;
  bit          m_byp, m_tdo, m_en;
  logic [31:0] m_id;

  function automatic int path_of(int op); // 0 bypass, 1 id, 2 boundary
    if (op == 0 || op == 1 || op == 6) return 2;
    if (op == 2 || op == 3) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] modes_of(int op); // sel, pin, core, hiz
    case (op)
      0: return 4'b1100;
      1: return 4'b1000;
      4: return 4'b0100;
      5: return 4'b0001;
      6: return 4'b1110;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_ir = 2; m_irsr = 0; m_byp = 0; m_id = EXP_ID;
    end else begin
      int old_sr, p;
      old_sr = m_irsr;
      p = path_of(m_ir);
      if (st_cap_ir) m_irsr = 1;
      else if (st_shift_ir) m_irsr = (m_irsr >> 1) | (int'(tdi) << (IR_W - 1));
      if (st_cap_dr) begin
        if (p == 0) m_byp = 0;
        if (p == 1) m_id = (m_ir == 3) ? user_code : EXP_ID;
      end else if (st_shift_dr) begin
        if (p == 0) m_byp = tdi;
        if (p == 1) m_id = {tdi, m_id[31:1]};
      end
      if (st_reset) m_ir = 2;
      else if (st_upd_ir) m_ir = old_sr;
    end
  end

  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_tdo = 0; m_en = 0;
    end else begin
      m_en = st_shift_ir | st_shift_dr;
      if (st_shift_ir) m_tdo = m_irsr[0];
      else if (st_shift_dr) begin
        case (path_of(m_ir))
          1: m_tdo = m_id[0];
          2: m_tdo = bsr_so;
          default: m_tdo = m_byp;
        endcase
      end else m_tdo = 0;
    end
  end

  always @(posedge tck) begin
    #6;
    if (cmp_on) begin
      chk("R11 tdo", {31'd0, tdo}, {31'd0, m_tdo});
      chk("R11 tdo_en", {31'd0, tdo_en}, {31'd0, m_en});
      chk("R5/R8/R9/R10 modes", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz},
          {28'd0, modes_of(m_ir)});
    end
  end

  // boundary-register serial data, changes between edges
  always @(posedge tck) begin
    #2;
    m_cnt++;
    bsr_so = m_cnt[0] ^ m_cnt[2];
  end

  // ---------------- stimulus tasks ----------------
  task automatic step(bit rs, bit ci, bit si, bit ui, bit cd, bit sd, bit d);
    @(posedge tck);
    #2;
    st_reset = rs; st_cap_ir = ci; st_shift_ir = si; st_upd_ir = ui;
    st_cap_dr = cd; st_shift_dr = sd; tdi = d;
    #4;
    last_tdo = tdo;
    last_en  = tdo_en;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load_ir(logic [IR_W-1:0] op);
    step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < IR_W; i++) step(0, 0, 1, 0, 0, 0, op[i]);
    step(0, 0, 0, 1, 0, 0, 0);
    idle(1);
  endtask

  task automatic scan_dr(int n, logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 1, din[i]);
      dout[i] = last_tdo;
    end
    idle(1);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  got;
    logic        pre;
    m_cnt = 0; bsr_so = 0;
    trst_n = 0; st_reset = 0; st_cap_ir = 0; st_shift_ir = 0; st_upd_ir = 0;
    st_cap_dr = 0; st_shift_dr = 0; tdi = 0; user_code = 32'hC0DE_5A17;
    #21;
    // R1: reset state
    chk("R1 reset modes", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'd0);
    chk("R1 reset tdo_en", {31'd0, tdo_en}, 32'd0);
    chk("R1 reset tdo", {31'd0, tdo}, 32'd0);
    @(posedge tck); #2 trst_n = 1;
    idle(3);
    cmp_on = 1;

    // R6 (and R1: IDCODE active after reset)
    scan_dr(32, 32'h0, d);
    chk("R6 id word", d, EXP_ID);

    // R2 capture pattern, then SAMPLE
    step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < IR_W; i++) begin
      step(0, 0, 1, 0, 0, 0, i == 0);
      got[i] = last_tdo;
      chk("R11 en in shift-IR", {31'd0, last_en}, 32'd1);
    end
    chk("R2 captured ir", {28'd0, got}, 32'h1);
    step(0, 0, 0, 1, 0, 0, 0);
    idle(1);
    chk("R11 en idle", {31'd0, tdo_en}, 32'd0);
    chk("R5 sample", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h8);
    scan_dr(8, 32'hA5, d);

    // R5 EXTEST
    load_ir(4'b0000);
    chk("R5 extest", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'hC);
    scan_dr(8, 32'h3C, d);

    // R3: shift CLAMP in, no update yet
    step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < IR_W; i++) step(0, 0, 1, 0, 0, 0, (4'b0100 >> i) & 1'b1);
    idle(2);
    chk("R3 hold before update", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'hC);
    step(0, 0, 0, 1, 0, 0, 0);
    idle(1);
    // R8 CLAMP
    chk("R8 clamp", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h4);
    scan_dr(4, 32'hD, d);
    chk("R8 clamp bypass path", d, 32'hA);

    // R4 BYPASS and unused
    load_ir(4'b1111);
    chk("R4 bypass modes", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h0);
    scan_dr(6, 32'h2D, d);
    chk("R4 bypass delay", d, 32'h1A);
    load_ir(4'b1001);
    chk("R4 unused modes", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h0);
    scan_dr(4, 32'h7, d);
    chk("R4 unused bypass", d, 32'hE);

    // R11 falling-edge timing
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    @(posedge tck); #2 st_shift_dr = 1; tdi = 0;
    #1 pre = tdo;
    chk("R11 tdo before fall", {31'd0, pre}, 32'd0);
    #2;
    chk("R11 tdo after fall", {31'd0, tdo}, 32'd1);
    #1;
    idle(1);

    // R9 HIGHZ
    load_ir(4'b0101);
    chk("R9 highz", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h1);
    scan_dr(4, 32'h9, d);
    chk("R9 highz bypass", d, 32'h2);

    // R10 INTEST
    load_ir(4'b0110);
    chk("R10 intest", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'hE);
    scan_dr(8, 32'h5A, d);

    // R7 USERCODE, later change ignored
    user_code = 32'hC0DE_5A17;
    load_ir(4'b0011);
    step(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 32; i++) begin
      step(0, 0, 0, 0, 0, 1, 0);
      if (i == 0) user_code = 32'h1234_8765;
      d[i] = last_tdo;
    end
    idle(1);
    chk("R7 user code", d, 32'hC0DE_5A17);

    // R1 test-logic-reset strobe
    load_ir(4'b0000);
    step(1, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R1 tlr modes", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h0);
    scan_dr(32, 32'h0, d);
    chk("R1 tlr gives idcode", d, EXP_ID);

    // R1 asynchronous reset mid-run
    load_ir(4'b0110);
    cmp_on = 0;
    trst_n = 0;
    #1;
    chk("R1 async reset modes", {28'd0, sel_bsr, pin_from_bsr, core_from_bsr, pins_hiz}, 32'h0);
    chk("R1 async reset en", {31'd0, tdo_en}, 32'd0);
    @(posedge tck); #2 trst_n = 1;
    idle(3);
    cmp_on = 1;
    scan_dr(32, 32'h0, d);
    chk("R1 idcode after async reset", d, EXP_ID);

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule